// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Processor Core

This block is a processor core that executes one instruction in every clock cycle for a subset of the RV32I integer instruction set. Within a single cycle it presents the program counter on the instruction port and decodes the returned word. It then reads up to two operands from a 32-entry register file, computes a result, a memory address or a jump target, and commits the register write, the store and the new program counter together on the next rising clock edge.

Instruction and data memories sit outside the block on two separate ports, and both are read combinationally. The data port is word addressed and carries a byte-enable mask that is always full, because only whole-word loads and stores exist here. Every instruction word that falls outside the supported subset is retired as a no-operation that still advances the program counter. The core raises a flag for that cycle so the surrounding system can react to it.

Top module: `rv_sc_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) loads the program counter with 0x00000000, so the first fetch after release is from address 0.
- R2: There are 32 registers of 32 bits. Register 0 always reads as zero, and an instruction whose destination is register 0 changes no register.
- R3: Register-register operations (opcode 0110011) compute add (funct3 000, bit 30 clear), sub (000, bit 30 set), sll (001), slt (010, signed), sltu (011), xor (100), srl (101, bit 30 clear), sra (101, bit 30 set), or (110) and and (111), with shift amounts taken from the low 5 bits of the second operand.
- R4: Immediate operations (opcode 0010011) apply the same funct3 operations to rs1 and the sign-extended 12-bit immediate in bits [31:20], with shifts using bits [24:20] and bit 30 selecting arithmetic right shift. LUI (0110111) writes {bits[31:12], 12'b0} and AUIPC (0010111) writes PC plus that value.
- R5: Conditional branches (opcode 1100011) compare rs1 with rs2 using funct3 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less and 111 unsigned greater-or-equal. The next PC is PC plus the B-format immediate when the comparison holds and PC+4 otherwise.
- R6: JAL (opcode 1101111) and JALR (opcode 1100111, funct3 000) write PC+4 to rd. The next PC is PC plus the J-format immediate for JAL, and rs1 plus the I-format immediate with bit 0 forced to 0 for JALR.
- R7: LW (opcode 0000011, funct3 010) drives `dmem_addr` with bits [31:2] of rs1 plus the I immediate, and writes the word returned on `dmem_rdata` in the same cycle to rd.
- R8: SW (opcode 0100011, funct3 010) raises `dmem_we` with `dmem_be` = 4'b1111, drives rs2 on `dmem_wdata`, and drives bits [31:2] of rs1 plus the S-format immediate on `dmem_addr`. Every other instruction keeps `dmem_we` low and `dmem_be` zero.
- R9: Each of the following is unsupported: any other opcode, load or store funct3 other than 010 (the byte and halfword forms), branch funct3 010 or 011, JALR funct3 other than 000, register-register funct7 other than 0000000 or 0100000 with funct3 000/101, and shift-immediate upper bits other than 0000000 or 0100000 (0100000 only for funct3 101). For an unsupported instruction `illegal_o` is high during its cycle, no register or memory is written, and the PC advances by 4. `illegal_o` is low for every supported instruction.
- R10: Operand reads are combinational and the register write lands at the clock edge. An instruction that reads and writes the same register uses the old value, and the following instruction sees the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state commits on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 30 | Word address of the load or store |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_be | output | 4 | Byte-enable mask of the store |
| dmem_wdata | output | 32 | Store data |
| illegal_o | output | 1 | High during the cycle of an unsupported instruction |

## Verification
The memory-side outputs (`dmem_we`, `dmem_be`, `dmem_addr`, `dmem_wdata`) and `illegal_o` belong to the instruction on `imem_rdata` in the same cycle. The bench drives each word at a falling edge and samples these outputs 1 ns later, before the commit edge. A register result only shows up one instruction later, so the bench reads it through a store of that register and checks the store data. The next PC shows up on `imem_addr` one rising edge after the instruction, and the bench samples it just after the following falling edge. Register-register and immediate operations are swept over a grid of operand values, with the expected results computed arithmetically in the bench.

// File: rtl/rv_sc_pkg.sv
// Shared types and encodings for the single-cycle core.
// Assumes a 32-bit datapath and 32 architectural registers.
package rv_sc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int REG_AW = $clog2(NREGS);

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;

    localparam logic [2:0] F3_WORD = 3'b010;

    // Execution class: groups instructions that share a datapath route
    typedef enum logic [2:0] {
        CLS_BAD, CLS_ALU, CLS_LOAD, CLS_STORE,
        CLS_JAL, CLS_JALR, CLS_BRANCH, CLS_AUIPC
    } exec_cls_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [2:0] {
        CMP_EQ, CMP_NE, CMP_LT, CMP_LTU,
        CMP_GE, CMP_GEU, CMP_ALWAYS, CMP_NEVER
    } cmp_op_e;

    // Decoded instruction record; each optional field carries its own valid flag
    typedef struct packed {
        exec_cls_e          cls;
        alu_op_e            alu_op;
        cmp_op_e            cmp_op;
        logic               rd_vld;
        logic [REG_AW-1:0]  rd;
        logic               ra_vld;
        logic [REG_AW-1:0]  ra;
        logic               rb_vld;
        logic [REG_AW-1:0]  rb;
        logic               imm_vld;
        logic [XLEN-1:0]    imm;
    } dec_rec_t;

endpackage

// File: rtl/rv_sc_decoder.sv
// Instruction decoder: turns a 32-bit word into a dec_rec_t record.
// Purely combinational. Unsupported words produce class CLS_BAD with
// no destination, so downstream logic commits nothing for them.
// A destination of register 0 is reported as "no destination".
module rv_sc_decoder
    import rv_sc_pkg::*;
(
    input  logic [31:0] inst_i,
    output dec_rec_t    dec_o
);

    logic [6:0]        opc;
    logic [2:0]        f3;
    logic [6:0]        f7;
    logic [REG_AW-1:0] rd_f, rs1_f, rs2_f;
    logic [31:0]       imm_i, imm_s, imm_b, imm_u, imm_j;

    // Field slicing and immediate reconstruction for all formats
    always_comb begin
        opc   = inst_i[6:0];
        rd_f  = inst_i[11:7];
        f3    = inst_i[14:12];
        rs1_f = inst_i[19:15];
        rs2_f = inst_i[24:20];
        f7    = inst_i[31:25];
        imm_i = {{20{inst_i[31]}}, inst_i[31:20]};
        imm_s = {{20{inst_i[31]}}, inst_i[31:25], inst_i[11:7]};
        imm_b = {{19{inst_i[31]}}, inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0};
        imm_u = {inst_i[31:12], 12'b0};
        imm_j = {{11{inst_i[31]}}, inst_i[31], inst_i[19:12], inst_i[20], inst_i[30:21], 1'b0};
    end

    // Map funct3 (plus the alternate bit) onto an ALU operation
    function automatic alu_op_e f3_to_alu(input logic [2:0] fn, input logic alt);
        case (fn)
            3'b000:  f3_to_alu = alt ? ALU_SUB : ALU_ADD;
            3'b001:  f3_to_alu = ALU_SLL;
            3'b010:  f3_to_alu = ALU_SLT;
            3'b011:  f3_to_alu = ALU_SLTU;
            3'b100:  f3_to_alu = ALU_XOR;
            3'b101:  f3_to_alu = alt ? ALU_SRA : ALU_SRL;
            3'b110:  f3_to_alu = ALU_OR;
            default: f3_to_alu = ALU_AND;
        endcase
    endfunction

    // Opcode dispatch and legality screening
    always_comb begin
        dec_o        = '0;
        dec_o.cls    = CLS_BAD;
        dec_o.alu_op = ALU_ADD;
        dec_o.cmp_op = CMP_NEVER;
        case (opc)
            OPC_OP: begin
                if (f7 == 7'b0000000 || (f7 == 7'b0100000 && (f3 == 3'b000 || f3 == 3'b101))) begin
                    dec_o.cls    = CLS_ALU;
                    dec_o.alu_op = f3_to_alu(f3, f7[5]);
                    dec_o.rd_vld = (rd_f != '0);
                    dec_o.rd     = rd_f;
                    dec_o.ra_vld = 1'b1;
                    dec_o.ra     = rs1_f;
                    dec_o.rb_vld = 1'b1;
                    dec_o.rb     = rs2_f;
                end
            end
            OPC_OPIMM: begin
                if ((f3 != 3'b001 && f3 != 3'b101) ||
                    (f3 == 3'b001 && f7 == 7'b0000000) ||
                    (f3 == 3'b101 && (f7 == 7'b0000000 || f7 == 7'b0100000))) begin
                    dec_o.cls     = CLS_ALU;
                    dec_o.alu_op  = f3_to_alu(f3, (f3 == 3'b101) && f7[5]);
                    dec_o.rd_vld  = (rd_f != '0);
                    dec_o.rd      = rd_f;
                    dec_o.ra_vld  = 1'b1;
                    dec_o.ra      = rs1_f;
                    dec_o.imm_vld = 1'b1;
                    dec_o.imm     = imm_i;
                end
            end
            OPC_LUI: begin
                dec_o.cls     = CLS_ALU;
                dec_o.rd_vld  = (rd_f != '0);
                dec_o.rd      = rd_f;
                dec_o.ra_vld  = 1'b1;
                dec_o.ra      = '0;
                dec_o.imm_vld = 1'b1;
                dec_o.imm     = imm_u;
            end
            OPC_AUIPC: begin
                dec_o.cls     = CLS_AUIPC;
                dec_o.rd_vld  = (rd_f != '0);
                dec_o.rd      = rd_f;
                dec_o.imm_vld = 1'b1;
                dec_o.imm     = imm_u;
            end
            OPC_JAL: begin
                dec_o.cls     = CLS_JAL;
                dec_o.cmp_op  = CMP_ALWAYS;
                dec_o.rd_vld  = (rd_f != '0);
                dec_o.rd      = rd_f;
                dec_o.imm_vld = 1'b1;
                dec_o.imm     = imm_j;
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    dec_o.cls     = CLS_JALR;
                    dec_o.cmp_op  = CMP_ALWAYS;
                    dec_o.rd_vld  = (rd_f != '0);
                    dec_o.rd      = rd_f;
                    dec_o.ra_vld  = 1'b1;
                    dec_o.ra      = rs1_f;
                    dec_o.imm_vld = 1'b1;
                    dec_o.imm     = imm_i;
                end
            end
            OPC_BRANCH: begin
                if (f3 != 3'b010 && f3 != 3'b011) begin
                    dec_o.cls     = CLS_BRANCH;
                    case (f3)
                        3'b000:  dec_o.cmp_op = CMP_EQ;
                        3'b001:  dec_o.cmp_op = CMP_NE;
                        3'b100:  dec_o.cmp_op = CMP_LT;
                        3'b101:  dec_o.cmp_op = CMP_GE;
                        3'b110:  dec_o.cmp_op = CMP_LTU;
                        default: dec_o.cmp_op = CMP_GEU;
                    endcase
                    dec_o.ra_vld  = 1'b1;
                    dec_o.ra      = rs1_f;
                    dec_o.rb_vld  = 1'b1;
                    dec_o.rb      = rs2_f;
                    dec_o.imm_vld = 1'b1;
                    dec_o.imm     = imm_b;
                end
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    dec_o.cls     = CLS_LOAD;
                    dec_o.rd_vld  = (rd_f != '0);
                    dec_o.rd      = rd_f;
                    dec_o.ra_vld  = 1'b1;
                    dec_o.ra      = rs1_f;
                    dec_o.imm_vld = 1'b1;
                    dec_o.imm     = imm_i;
                end
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    dec_o.cls     = CLS_STORE;
                    dec_o.ra_vld  = 1'b1;
                    dec_o.ra      = rs1_f;
                    dec_o.rb_vld  = 1'b1;
                    dec_o.rb      = rs2_f;
                    dec_o.imm_vld = 1'b1;
                    dec_o.imm     = imm_s;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rv_sc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is hard-wired to zero; writes land at the rising clock edge,
// so a read in the same cycle as a write returns the previous contents.
// Assumes a synchronous active-low reset that clears every entry.
module rv_sc_regfile #(
    parameter int NREGS = 32,
    parameter int DW    = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1_i,
    output logic [DW-1:0] rd1_o,
    input  logic [AW-1:0] ra2_i,
    output logic [DW-1:0] rd2_o,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i
);

    logic [DW-1:0] regs [NREGS];

    // One storage element per entry; entry 0 is a constant zero
    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            // Capture write data when this entry is addressed
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (we_i && wa_i == AW'(g)) begin
                    regs[g] <= wd_i;
                end
            end
        end
    end

    // Asynchronous read ports
    assign rd1_o = regs[ra1_i];
    assign rd2_o = regs[ra2_i];

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1_i == '0) |-> (rd1_o == '0));

    assert_zero_reg_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra2_i == '0) |-> (rd2_o == '0));

endmodule

// File: rtl/rv_sc_alu.sv
// Integer ALU for the core: arithmetic, logic, compare-to-set and shifts.
// Combinational; shift amounts use the low log2(W) bits of operand b.
module rv_sc_alu
    import rv_sc_pkg::*;
#(
    parameter int W    = 32,
    localparam int SHW = $clog2(W)
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    logic [SHW-1:0] shamt;

    // Operation select
    always_comb begin
        shamt = b_i[SHW-1:0];
        case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_OR:   y_o = a_i | b_i;
            ALU_XOR:  y_o = a_i ^ b_i;
            ALU_SLT:  y_o = W'($signed(a_i) < $signed(b_i));
            ALU_SLTU: y_o = W'(a_i < b_i);
            ALU_SLL:  y_o = a_i << shamt;
            ALU_SRL:  y_o = a_i >> shamt;
            ALU_SRA:  y_o = $unsigned($signed(a_i) >>> shamt);
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/rv_sc_cmp.sv
// Branch condition unit: decides whether control leaves the PC+4 path.
// Combinational; jumps use CMP_ALWAYS and non-control classes CMP_NEVER.
module rv_sc_cmp
    import rv_sc_pkg::*;
#(
    parameter int W = 32
) (
    input  cmp_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         taken_o
);

    // Condition evaluation
    always_comb begin
        case (op_i)
            CMP_EQ:     taken_o = (a_i == b_i);
            CMP_NE:     taken_o = (a_i != b_i);
            CMP_LT:     taken_o = ($signed(a_i) <  $signed(b_i));
            CMP_GE:     taken_o = ($signed(a_i) >= $signed(b_i));
            CMP_LTU:    taken_o = (a_i <  b_i);
            CMP_GEU:    taken_o = (a_i >= b_i);
            CMP_ALWAYS: taken_o = 1'b1;
            default:    taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rv_sc_core.sv
// Single-cycle core top: fetch, decode, operand read, execute and commit
// happen in one cycle; PC, register write and store commit together at
// the rising edge. Assumes both memories answer combinationally and
// that the reset is synchronous and active low.
module rv_sc_core
    import rv_sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    localparam int         DM_AW    = XLEN - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [31:0]      imem_rdata,
    output logic [DM_AW-1:0] dmem_addr,
    input  logic [XLEN-1:0]  dmem_rdata,
    output logic             dmem_we,
    output logic [3:0]       dmem_be,
    output logic [XLEN-1:0]  dmem_wdata,
    output logic             illegal_o
);

    logic [XLEN-1:0]   pc_q, pc_d, pc_inc, pc_rel, jump_tgt;
    dec_rec_t          dec;
    logic [REG_AW-1:0] rf_ra1, rf_ra2;
    logic [XLEN-1:0]   op_a, op_b, alu_b, alu_y, wb_val;
    logic              taken;
    logic [1:0]        unused_byte_ofs;

    // Decode stage
    rv_sc_decoder u_dec (
        .inst_i (imem_rdata),
        .dec_o  (dec)
    );

    // Invalid source slots read entry 0, which is constant zero
    assign rf_ra1 = dec.ra_vld ? dec.ra : '0;
    assign rf_ra2 = dec.rb_vld ? dec.rb : '0;

    rv_sc_regfile #(.NREGS(NREGS), .DW(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1_i (rf_ra1),
        .rd1_o (op_a),
        .ra2_i (rf_ra2),
        .rd2_o (op_b),
        .we_i  (dec.rd_vld),
        .wa_i  (dec.rd),
        .wd_i  (wb_val)
    );

    // Second ALU operand: immediate when present, except branches compare registers
    assign alu_b = (dec.imm_vld && dec.cls != CLS_BRANCH) ? dec.imm : op_b;

    rv_sc_alu #(.W(XLEN)) u_alu (
        .op_i (dec.alu_op),
        .a_i  (op_a),
        .b_i  (alu_b),
        .y_o  (alu_y)
    );

    rv_sc_cmp #(.W(XLEN)) u_cmp (
        .op_i    (dec.cmp_op),
        .a_i     (op_a),
        .b_i     (op_b),
        .taken_o (taken)
    );

    // Next-PC candidates and selection
    always_comb begin
        pc_inc   = pc_q + XLEN'(4);
        pc_rel   = pc_q + dec.imm;
        jump_tgt = (dec.cls == CLS_JALR) ? {alu_y[XLEN-1:1], 1'b0} : pc_rel;
        pc_d     = taken ? jump_tgt : pc_inc;
    end

    // Writeback value by execution class
    always_comb begin
        case (dec.cls)
            CLS_JAL, CLS_JALR: wb_val = pc_inc;
            CLS_AUIPC:         wb_val = pc_rel;
            CLS_LOAD:          wb_val = dmem_rdata;
            default:           wb_val = alu_y;
        endcase
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign imem_addr       = pc_q;
    assign dmem_addr       = alu_y[XLEN-1:2];
    assign unused_byte_ofs = alu_y[1:0];
    assign dmem_we         = (dec.cls == CLS_STORE);
    assign dmem_be         = dmem_we ? 4'b1111 : 4'b0000;
    assign dmem_wdata      = op_b;
    assign illegal_o       = (dec.cls == CLS_BAD);

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (imem_addr == RESET_PC));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!dmem_we && !dec.rd_vld));

    assert_illegal_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> (imem_addr == $past(imem_addr) + 32'd4));

    assert_branch_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.cls == CLS_BRANCH && !taken) |=> (imem_addr == $past(imem_addr) + 32'd4));

    assert_jalr_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.cls == CLS_JALR) |=> (imem_addr[0] == 1'b0));

    assert_store_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (dmem_be == 4'b1111));

endmodule

// File: tb/rv_sc_core_tb.sv
`timescale 1ns/1ps
module rv_sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_rdata, dmem_wdata;
    logic [29:0] dmem_addr;
    logic        dmem_we, illegal_o;
    logic [3:0]  dmem_be;
    logic [31:0] dmem [64];
    int          n_tests = 0;
    int          n_fail = 0;

    localparam logic [31:0] NOP = 32'h0000_0013;

    always #2.5 clk = ~clk;

    rv_sc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .dmem_be    (dmem_be),
        .dmem_wdata (dmem_wdata),
        .illegal_o  (illegal_o)
    );

    assign dmem_rdata = dmem[dmem_addr[5:0]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                          input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2, rs1,
                                          input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2, rs1,
                                          input logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] opnd(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'h0000_001F;
            default: return 32'hF0F0_0A05;
        endcase
    endfunction

    function automatic logic [11:0] immv(input int k);
        case (k)
            0: return 12'h000;
            1: return 12'h001;
            2: return 12'hFFF;
            3: return 12'h7FF;
            4: return 12'h800;
            5: return 12'h555;
            6: return 12'h01F;
            default: return 12'h0A3;
        endcase
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] f3, input logic alt,
                                            input logic [31:0] a, b);
        case (f3)
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << b[4:0];
            3'd2: return {31'd0, $signed(a) < $signed(b)};
            3'd3: return {31'd0, a < b};
            3'd4: return a ^ b;
            3'd5: return alt ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic ref_br(input logic [2:0] f3, input logic [31:0] a, b);
        case (f3)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a < b;
            default: return a >= b;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one instruction for a cycle; outputs are sampled 1 ns after the falling edge
    task automatic step(input logic [31:0] ins);
        @(negedge clk);
        imem_rdata = ins;
        #1;
    endtask

    task automatic load_const(input logic [4:0] r, input logic [31:0] v);
        logic [31:0] hi;
        hi = v + 32'h800;
        step({hi[31:12], r, 7'b0110111});
        step(enc_i(v[11:0], r, 3'b000, r, 7'b0010011));
    endtask

    // Bring a register out through the store data port
    task automatic peek(input logic [4:0] r, output logic [31:0] v);
        step(enc_s(12'h0, r, 5'd0, 3'b010));
        v = dmem_wdata;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, pc0, exp_pc;
        logic [11:0] im;
        logic [2:0]  f3;
        logic        alt;
        imem_rdata = NOP;
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pc in reset", imem_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 first fetch", imem_addr, 32'h0);
        chk("R8 no store on nop", {31'd0, dmem_we}, 32'd0);
        chk("R8 mask idle", {28'd0, dmem_be}, 32'd0);

        // R3: register-register sweep
        for (int op = 0; op < 10; op++) begin
            case (op)
                0: begin f3 = 3'd0; alt = 1'b0; end
                1: begin f3 = 3'd0; alt = 1'b1; end
                2: begin f3 = 3'd1; alt = 1'b0; end
                3: begin f3 = 3'd2; alt = 1'b0; end
                4: begin f3 = 3'd3; alt = 1'b0; end
                5: begin f3 = 3'd4; alt = 1'b0; end
                6: begin f3 = 3'd5; alt = 1'b0; end
                7: begin f3 = 3'd5; alt = 1'b1; end
                8: begin f3 = 3'd6; alt = 1'b0; end
                default: begin f3 = 3'd7; alt = 1'b0; end
            endcase
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    a = opnd(i); b = opnd(j);
                    load_const(5'd1, a);
                    load_const(5'd2, b);
                    step(enc_r({1'b0, alt, 5'd0}, 5'd2, 5'd1, f3, 5'd3));
                    chk("R3 legal flag", {31'd0, illegal_o}, 32'd0);
                    peek(5'd3, v);
                    chk("R3 reg-reg result", v, ref_alu(f3, alt, a, b));
                end
            end
        end

        // R4: immediate sweep (shifts use a 5-bit amount and bit 30)
        for (int op = 0; op < 9; op++) begin
            case (op)
                0: begin f3 = 3'd0; alt = 1'b0; end
                1: begin f3 = 3'd2; alt = 1'b0; end
                2: begin f3 = 3'd3; alt = 1'b0; end
                3: begin f3 = 3'd4; alt = 1'b0; end
                4: begin f3 = 3'd6; alt = 1'b0; end
                5: begin f3 = 3'd7; alt = 1'b0; end
                6: begin f3 = 3'd1; alt = 1'b0; end
                7: begin f3 = 3'd5; alt = 1'b0; end
                default: begin f3 = 3'd5; alt = 1'b1; end
            endcase
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    a = opnd(i);
                    im = immv(j);
                    if (f3 == 3'd1 || f3 == 3'd5) im = {1'b0, alt, 5'd0, im[4:0]};
                    load_const(5'd1, a);
                    step(enc_i(im, 5'd1, f3, 5'd4, 7'b0010011));
                    chk("R4 legal flag", {31'd0, illegal_o}, 32'd0);
                    peek(5'd4, v);
                    chk("R4 imm result", v, ref_alu(f3, alt, a, {{20{im[11]}}, im}));
                end
            end
        end

        // R4: LUI and AUIPC
        for (int k = 0; k < 8; k++) begin
            b = opnd(k);
            step({b[19:0], 5'd6, 7'b0110111});
            peek(5'd6, v);
            chk("R4 lui", v, {b[19:0], 12'd0});
            step({b[19:0], 5'd7, 7'b0010111});
            pc0 = imem_addr;
            peek(5'd7, v);
            chk("R4 auipc", v, pc0 + {b[19:0], 12'd0});
        end

        // R5: branch sweep, taken offset alternates forward and backward
        for (int c = 0; c < 6; c++) begin
            case (c)
                0: f3 = 3'd0; 1: f3 = 3'd1; 2: f3 = 3'd4;
                3: f3 = 3'd5; 4: f3 = 3'd6; default: f3 = 3'd7;
            endcase
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    a = opnd(i); b = opnd(j);
                    load_const(5'd1, a);
                    load_const(5'd2, b);
                    im = ((i + j) % 2 == 0) ? 12'h010 : 12'hFF8;
                    step(enc_b({im[11], im}, 5'd2, 5'd1, f3));
                    pc0 = imem_addr;
                    exp_pc = ref_br(f3, a, b) ? pc0 + {{20{im[11]}}, im} : pc0 + 32'd4;
                    step(NOP);
                    chk("R5 branch next pc", imem_addr, exp_pc);
                end
            end
        end

        // R6: JAL forward/backward and JALR with odd sum
        step(enc_j(21'h000100, 5'd5));
        pc0 = imem_addr;
        step(NOP);
        chk("R6 jal target", imem_addr, pc0 + 32'h100);
        peek(5'd5, v);
        chk("R6 jal link", v, pc0 + 32'd4);
        step(enc_j(21'h1FFFF8, 5'd5));
        pc0 = imem_addr;
        step(NOP);
        chk("R6 jal back", imem_addr, pc0 - 32'd8);
        load_const(5'd1, 32'h0000_0100);
        step(enc_i(12'h005, 5'd1, 3'b000, 5'd6, 7'b1100111));
        pc0 = imem_addr;
        step(NOP);
        chk("R6 jalr target bit0 clear", imem_addr, 32'h0000_0104);
        peek(5'd6, v);
        chk("R6 jalr link", v, pc0 + 32'd4);

        // R2: destination x0 discarded
        step(enc_i(12'h07B, 5'd0, 3'b000, 5'd0, 7'b0010011));
        peek(5'd0, v);
        chk("R2 addi x0", v, 32'h0);
        step({20'hABCDE, 5'd0, 7'b0110111});
        peek(5'd0, v);
        chk("R2 lui x0", v, 32'h0);
        step(enc_j(21'h000008, 5'd0));
        peek(5'd0, v);
        chk("R2 jal x0", v, 32'h0);

        // R8 and R7: store then load back, positive and negative offsets
        load_const(5'd1, 32'hCAFE_F00D);
        load_const(5'd2, 32'h0000_0040);
        step(enc_s(12'h008, 5'd1, 5'd2, 3'b010));
        chk("R8 store strobe", {31'd0, dmem_we}, 32'd1);
        chk("R8 store mask", {28'd0, dmem_be}, 32'hF);
        chk("R8 store word addr", {2'd0, dmem_addr}, 32'h12);
        chk("R8 store data", dmem_wdata, 32'hCAFE_F00D);
        step(enc_i(12'h008, 5'd2, 3'b010, 5'd7, 7'b0000011));
        chk("R7 load word addr", {2'd0, dmem_addr}, 32'h12);
        chk("R7 load no strobe", {31'd0, dmem_we}, 32'd0);
        peek(5'd7, v);
        chk("R7 load result", v, 32'hCAFE_F00D);
        load_const(5'd1, 32'h1357_9BDF);
        load_const(5'd2, 32'h0000_0080);
        step(enc_s(12'hFFC, 5'd1, 5'd2, 3'b010));
        chk("R8 store neg offset addr", {2'd0, dmem_addr}, 32'h1F);
        step(enc_i(12'hFFC, 5'd2, 3'b010, 5'd8, 7'b0000011));
        peek(5'd8, v);
        chk("R7 load neg offset", v, 32'h1357_9BDF);

        // R9: unsupported encodings leave registers, memory and PC flow intact
        load_const(5'd9, 32'h0000_1111);
        load_const(5'd1, 32'h0000_0044);
        for (int k = 0; k < 11; k++) begin
            case (k)
                0: v = enc_i(12'h0, 5'd0, 3'b000, 5'd9, 7'b0000011);
                1: v = enc_i(12'h0, 5'd0, 3'b001, 5'd9, 7'b0000011);
                2: v = enc_i(12'h0, 5'd0, 3'b100, 5'd9, 7'b0000011);
                3: v = enc_i(12'h0, 5'd0, 3'b101, 5'd9, 7'b0000011);
                4: v = enc_s(12'h0, 5'd1, 5'd0, 3'b000);
                5: v = enc_s(12'h0, 5'd1, 5'd0, 3'b001);
                6: v = {25'd0, 5'd9, 2'b00} | 32'h0000_0000;
                7: v = enc_b(13'h0010, 5'd0, 5'd0, 3'b010);
                8: v = enc_r(7'b0000001, 5'd1, 5'd1, 3'b000, 5'd9);
                9: v = enc_i(12'h401, 5'd1, 3'b001, 5'd9, 7'b0010011);
                default: v = enc_i(12'h0, 5'd1, 3'b001, 5'd9, 7'b1100111);
            endcase
            step(v);
            pc0 = imem_addr;
            chk("R9 illegal flag", {31'd0, illegal_o}, 32'd1);
            chk("R9 no store", {31'd0, dmem_we}, 32'd0);
            step(NOP);
            chk("R9 pc plus 4", imem_addr, pc0 + 32'd4);
            chk("R9 flag clears", {31'd0, illegal_o}, 32'd0);
            peek(5'd9, v);
            chk("R9 rd unchanged", v, 32'h0000_1111);
            chk("R9 memory word untouched", dmem[17], 32'h0);
        end

        // R10: read-modify-write of one register within a cycle
        load_const(5'd4, 32'd10);
        step(enc_r(7'd0, 5'd4, 5'd4, 3'b000, 5'd4));
        peek(5'd4, v);
        chk("R10 same-cycle old value", v, 32'd20);
        step(enc_r(7'd0, 5'd4, 5'd4, 3'b000, 5'd4));
        step(enc_i(12'h001, 5'd4, 3'b000, 5'd4, 7'b0010011));
        peek(5'd4, v);
        chk("R10 chained update", v, 32'd41);

        // R1: reset in mid-run returns PC to zero
        step(enc_j(21'h000400, 5'd0));
        step(NOP);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset pc", imem_addr, 32'h0);
        rst_n = 1'b1;
        step(NOP);
        chk("R1 fetch after reset", imem_addr, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule